// File: doc/BRIEF.md
# Guest Interval Timer with Match Interrupt

This block gives a guest a private cycle counter and a one-shot match timer. The guest count is formed from a free-running host count plus a stored offset. Whatever the host count does, for instance stepping back when the guest moves to another core, successive reads never return a smaller value than the one returned before, unless the guest itself rewrites the counter. Writing the counter moves the offset so that the guest count equals the written value from then on.

A match register and a control register (an 8-bit vector and a mask bit) describe the timer interrupt. Writing the match register arms the timer. When the guest count reaches the match value, the timer fires once. If the mask bit is clear, it sends a single-cycle set strobe with the vector toward an external pending-interrupt bitmap. Writes to the match, counter and control registers keep that bitmap consistent: they send clear strobes for a stale timer bit, and they move a pending bit to a new vector number. The bitmap reports whether the current vector is pending through one input bit.

Top module: `gtc_top`

## Requirements
- R1: A read strobe returns the guest count, host count plus offset, on `cnt_rdata`, with `cnt_rvalid` high in the cycle after the strobe.
- R2: If host count plus offset is not strictly greater, as a signed difference, than the last returned count, a read returns the last returned count. Reads between counter writes therefore never decrease.
- R3: A counter write sets the offset to the written value minus the current host count, and sets the last returned count to the written value.
- R4: In reset the offset and match are 0, the armed flag is clear, and the control register is 0x10000 (mask in bit 16 set, vector in bits 7:0 equal to 0). The last returned count takes the host count. Both strobes are low in the first cycle after reset.
- R5: A match write arms the timer. An armed timer fires once, in the first cycle with no register write where the signed difference guest count minus match is >= 0. Firing disarms the timer and refreshes the last returned count. If the timer is unmasked, the next cycle carries one `set_stb` pulse with `set_vec` equal to the vector.
- R6: A firing while the mask is set produces no set strobe, and it still uses up the arming. Unmasking afterwards raises nothing.
- R7: Every honoured match write gives a `clr_stb` pulse in the next cycle, with `clr_vec` equal to the vector programmed before the write.
- R8: A counter write whose value is greater than the match value, by signed difference, gives a `clr_stb` for the current vector and disarms the timer. A counter write that does not pass the match value gives no clear strobe.
- R9: A control write with bit 16 set gives a `clr_stb` carrying the old vector.
- R10: A control write with bit 16 clear and a different vector, while `pend_at_vec` is 1, gives in the same cycle a `clr_stb` for the old vector and a `set_stb` for the new one. With `pend_at_vec` 0, or with the same vector, it gives no strobe.
- R11: At most one register write is honoured per cycle, in the priority counter, then match, then control. A losing write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cnt | input | CW | Free-running host cycle count |
| cnt_rd | input | 1 | Read strobe for the guest count |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CW | Counter write value |
| match_wr | input | 1 | Match write strobe |
| match_wdata | input | CW | Match write value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 17 | Control value: bit 16 mask, bits 7:0 vector |
| pend_at_vec | input | 1 | Bitmap state of the bit at `probe_vec` |
| cnt_rdata | output | CW | Returned guest count |
| cnt_rvalid | output | 1 | `cnt_rdata` updated this cycle |
| set_stb | output | 1 | Single-cycle request to set a pending bit |
| set_vec | output | 8 | Vector for `set_stb` |
| clr_stb | output | 1 | Single-cycle request to clear a pending bit |
| clr_vec | output | 8 | Vector for `clr_stb` |
| probe_vec | output | 8 | Currently programmed timer vector |

## Verification
The match compare is driven with a table of counter and match pairs. The table covers a match behind the count, one equal to it and one just ahead, plus one pair on each side of the wrap point. This separates a signed compare from an unsigned one and separates `>=` from `>`. A directed run lets the host count tick so that the timer fires exactly once on its own. The host count is also stepped backwards, which separates a clamped read from a raw sum. The control register is written masked, unmasked with the same vector, and unmasked with a new vector with and without `pend_at_vec`. Writes that collide in one cycle show which one wins.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int VW       = 8;
  localparam int CTL_W    = 17;
  localparam int MASK_POS = 16;
  localparam logic [CTL_W-1:0] CTL_RST = 17'h10000;

  typedef enum logic [1:0] {
    WSEL_NONE  = 2'd0,
    WSEL_CNT   = 2'd1,
    WSEL_MATCH = 2'd2,
    WSEL_CTL   = 2'd3
  } wsel_e;
endpackage

// File: rtl/gtc_count.sv
module gtc_count #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] host_cnt,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          refresh,
  output logic [CW-1:0] now_cnt,
  output logic [CW-1:0] rdata,
  output logic          rvalid
);
  logic [CW-1:0] off_q;
  logic [CW-1:0] last_q;
  logic [CW-1:0] raw;
  logic [CW-1:0] ahead;

  // raw guest count and its distance from the last returned value
  always_comb begin
    raw   = host_cnt + off_q;
    ahead = raw - last_q;
    // strictly ahead: sign clear and nonzero
    if (!ahead[CW-1] && (|ahead)) now_cnt = raw;
    else                          now_cnt = last_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      last_q <= host_cnt;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= now_cnt;
      if (wr_en) begin
        off_q  <= wr_data - host_cnt;
        last_q <= wr_data;
      end else if (rd_en || refresh) begin
        last_q <= now_cnt;
      end
    end
  end
endmodule

// File: rtl/gtc_match.sv
module gtc_match #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] now_cnt,
  input  logic          any_wr,
  input  logic          match_wr,
  input  logic [CW-1:0] match_data,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_data,
  output logic          fire,
  output logic          cancel
);
  logic [CW-1:0] match_q;
  logic          armed_q;
  logic [CW-1:0] gap_now;
  logic [CW-1:0] gap_new;

  always_comb begin
    gap_now = now_cnt - match_q;
    gap_new = cnt_data - match_q;
    // expiry: guest count at or past match, judged by sign
    fire    = armed_q && !any_wr && !gap_now[CW-1];
    // a counter write that jumps past the match value
    cancel  = cnt_wr && !gap_new[CW-1] && (|gap_new);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      armed_q <= 1'b0;
    end else if (match_wr) begin
      match_q <= match_data;
      armed_q <= 1'b1;
    end else if (cancel || fire) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gtc_vecctl.sv
module gtc_vecctl
  import gtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic             match_wr,
  input  logic             cancel,
  input  logic             fire,
  input  logic             pend_at_vec,
  output logic             set_stb,
  output logic [VW-1:0]    set_vec,
  output logic             clr_stb,
  output logic [VW-1:0]    clr_vec,
  output logic [VW-1:0]    cur_vec,
  output logic             masked
);
  logic [CTL_W-1:0] ctl_q;
  logic [VW-1:0]    new_vec;
  logic             new_mask;

  assign cur_vec  = ctl_q[VW-1:0];
  assign masked   = ctl_q[MASK_POS];
  assign new_vec  = ctl_data[VW-1:0];
  assign new_mask = ctl_data[MASK_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTL_RST;
      set_stb <= 1'b0;
      set_vec <= '0;
      clr_stb <= 1'b0;
      clr_vec <= '0;
    end else begin
      set_stb <= 1'b0;
      clr_stb <= 1'b0;
      if (match_wr || cancel) begin
        clr_stb <= 1'b1;
        clr_vec <= cur_vec;
      end
      if (ctl_wr) begin
        ctl_q <= ctl_data;
        if (new_mask) begin
          clr_stb <= 1'b1;
          clr_vec <= cur_vec;
        end else if ((new_vec != cur_vec) && pend_at_vec) begin
          clr_stb <= 1'b1;
          clr_vec <= cur_vec;
          set_stb <= 1'b1;
          set_vec <= new_vec;
        end
      end
      if (fire && !masked) begin
        set_stb <= 1'b1;
        set_vec <= cur_vec;
      end
    end
  end
endmodule

// File: rtl/gtc_top.sv
module gtc_top
  import gtc_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    host_cnt,
  input  logic             cnt_rd,
  input  logic             cnt_wr,
  input  logic [CW-1:0]    cnt_wdata,
  input  logic             match_wr,
  input  logic [CW-1:0]    match_wdata,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             pend_at_vec,
  output logic [CW-1:0]    cnt_rdata,
  output logic             cnt_rvalid,
  output logic             set_stb,
  output logic [VW-1:0]    set_vec,
  output logic             clr_stb,
  output logic [VW-1:0]    clr_vec,
  output logic [VW-1:0]    probe_vec
);
  wsel_e         wsel;
  logic          go_cnt, go_match, go_ctl, any_wr;
  logic [CW-1:0] now_cnt;
  logic          fire, cancel;
  logic          tmr_masked;

  // one write per cycle: counter beats match beats control
  always_comb begin
    if (cnt_wr)        wsel = WSEL_CNT;
    else if (match_wr) wsel = WSEL_MATCH;
    else if (ctl_wr)   wsel = WSEL_CTL;
    else               wsel = WSEL_NONE;
  end

  assign go_cnt   = (wsel == WSEL_CNT);
  assign go_match = (wsel == WSEL_MATCH);
  assign go_ctl   = (wsel == WSEL_CTL);
  assign any_wr   = (wsel != WSEL_NONE);

  gtc_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst     (rst),
    .host_cnt(host_cnt),
    .rd_en   (cnt_rd),
    .wr_en   (go_cnt),
    .wr_data (cnt_wdata),
    .refresh (fire),
    .now_cnt (now_cnt),
    .rdata   (cnt_rdata),
    .rvalid  (cnt_rvalid)
  );

  gtc_match #(.CW(CW)) u_match (
    .clk       (clk),
    .rst       (rst),
    .now_cnt   (now_cnt),
    .any_wr    (any_wr),
    .match_wr  (go_match),
    .match_data(match_wdata),
    .cnt_wr    (go_cnt),
    .cnt_data  (cnt_wdata),
    .fire      (fire),
    .cancel    (cancel)
  );

  gtc_vecctl u_vecctl (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr     (go_ctl),
    .ctl_data   (ctl_wdata),
    .match_wr   (go_match),
    .cancel     (cancel),
    .fire       (fire),
    .pend_at_vec(pend_at_vec),
    .set_stb    (set_stb),
    .set_vec    (set_vec),
    .clr_stb    (clr_stb),
    .clr_vec    (clr_vec),
    .cur_vec    (probe_vec),
    .masked     (tmr_masked)
  );
endmodule

// File: rtl/gtc_checker.sv
module gtc_checker
  import gtc_pkg::*;
#(
  parameter int CW = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_wr,
  input logic             match_wr,
  input logic             ctl_wr,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [CW-1:0]    cnt_rdata,
  input logic             cnt_rvalid,
  input logic             set_stb,
  input logic             clr_stb,
  input logic [VW-1:0]    clr_vec,
  input logic [VW-1:0]    probe_vec,
  input logic             masked
);
  logic [CW-1:0] prev_rd;
  logic          have_prev;
  logic          wr_d;
  logic [CW-1:0] rd_step;

  assign rd_step = cnt_rdata - prev_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rd   <= '0;
      have_prev <= 1'b0;
      wr_d      <= 1'b0;
    end else begin
      wr_d <= cnt_wr;
      if (cnt_wr || wr_d) have_prev <= 1'b0;
      else if (cnt_rvalid) begin
        have_prev <= 1'b1;
        prev_rd   <= cnt_rdata;
      end
    end
  end

  p_rd_order_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_rvalid && have_prev) |-> !rd_step[CW-1]);

  p_reset_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!set_stb && !clr_stb));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (masked && !ctl_wr) |=> !set_stb);

  p_match_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (match_wr && !cnt_wr) |=> (clr_stb && clr_vec == $past(probe_vec)));

  p_mask_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[MASK_POS] && !cnt_wr && !match_wr)
      |=> (clr_stb && clr_vec == $past(probe_vec)));

  p_wr_prio_r11: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && (cnt_wr || match_wr)) |=> $stable(probe_vec));
endmodule

bind gtc_top gtc_checker #(.CW(CW)) u_gtc_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_wr    (cnt_wr),
  .match_wr  (match_wr),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .cnt_rdata (cnt_rdata),
  .cnt_rvalid(cnt_rvalid),
  .set_stb   (set_stb),
  .clr_stb   (clr_stb),
  .clr_vec   (clr_vec),
  .probe_vec (probe_vec),
  .masked    (tmr_masked)
);

// File: tb/gtc_top_bench.sv
module gtc_top_bench;
  localparam int CW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] host_cnt = 64'd500;
  logic          cnt_rd = 1'b0;
  logic          cnt_wr = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic          match_wr = 1'b0;
  logic [CW-1:0] match_wdata = '0;
  logic          ctl_wr = 1'b0;
  logic [16:0]   ctl_wdata = '0;
  logic          pend_at_vec = 1'b0;
  logic [CW-1:0] cnt_rdata;
  logic          cnt_rvalid;
  logic          set_stb;
  logic [7:0]    set_vec;
  logic          clr_stb;
  logic [7:0]    clr_vec;
  logic [7:0]    probe_vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gtc_top #(.CW(CW)) u_gtc_top (
    .clk(clk), .rst(rst), .host_cnt(host_cnt), .cnt_rd(cnt_rd),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .match_wr(match_wr),
    .match_wdata(match_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .pend_at_vec(pend_at_vec), .cnt_rdata(cnt_rdata), .cnt_rvalid(cnt_rvalid),
    .set_stb(set_stb), .set_vec(set_vec), .clr_stb(clr_stb),
    .clr_vec(clr_vec), .probe_vec(probe_vec)
  );

  // {host, counter write, match write, expect fire}
  localparam logic [192:0] TBL [5] = '{
    {64'd7,                  64'd100,                64'd50,                 1'b1},
    {64'd1000,               64'd100,                64'd100,                1'b1},
    {64'hFFFF_FFFF_FFFF_FF00,64'd100,                64'd101,                1'b0},
    {64'd3,                  64'hFFFF_FFFF_FFFF_FFF0,64'h10,                 1'b0},
    {64'd42,                 64'h10,                 64'hFFFF_FFFF_FFFF_FFF0,1'b1}
  };

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] ctlv(input logic m, input logic [7:0] v);
    return {m, 8'h00, v};
  endfunction

  task automatic wr_cnt(input logic [CW-1:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic wr_match(input logic [CW-1:0] v);
    match_wr = 1'b1; match_wdata = v;
    @(negedge clk);
    match_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [16:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic rd(output logic [CW-1:0] v, output logic vld);
    cnt_rd = 1'b1;
    @(negedge clk);
    cnt_rd = 1'b0;
    v = cnt_rdata; vld = cnt_rvalid;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count set pulses carrying a given vector over n cycles
  task automatic count_sets(input int n, input logic [7:0] v, output int hits, output int any);
    hits = 0; any = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (set_stb) begin
        any++;
        if (set_vec == v) hits++;
      end
    end
  endtask

  initial begin
    logic [CW-1:0] rv;
    logic          vl;
    int            hits, any;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R4: reset state
    chk("R4 set_stb after reset", {63'd0, set_stb}, 64'd0);
    chk("R4 clr_stb after reset", {63'd0, clr_stb}, 64'd0);
    chk("R4 vector after reset", {56'd0, probe_vec}, 64'd0);
    rd(rv, vl);
    chk("R1 rvalid", {63'd0, vl}, 64'd1);
    chk("R4 count after reset equals host", rv, 64'd500);

    // R3, R1, R2: offset and clamping
    host_cnt = 64'd0;
    wr_cnt(64'd1000);
    host_cnt = 64'd10;
    rd(rv, vl);
    chk("R3 count after write plus host", rv, 64'd1010);
    host_cnt = 64'd5;
    rd(rv, vl);
    chk("R2 clamp on host step back", rv, 64'd1010);
    host_cnt = 64'd20;
    rd(rv, vl);
    chk("R1 count follows host again", rv, 64'd1020);

    // R6 masked firing, R7 match clear
    host_cnt = 64'd0;
    wr_cnt(64'd100);
    idle(2);
    wr_match(64'd50);
    chk("R7 clr_stb on match write", {63'd0, clr_stb}, 64'd1);
    chk("R7 clr_vec on match write", {56'd0, clr_vec}, 64'd0);
    count_sets(4, 8'd0, hits, any);
    chk("R6 no set while masked", any, 64'd0);
    wr_ctl(ctlv(1'b0, 8'h21));
    chk("R10 same-state unmask no clr", {63'd0, clr_stb}, 64'd0);
    count_sets(4, 8'h21, hits, any);
    chk("R6 arming used up while masked", any, 64'd0);

    // R5: table of compare cases
    for (int i = 0; i < 5; i++) begin
      logic [7:0] v;
      v = 8'h60 + 8'(i);
      wr_ctl(ctlv(1'b1, v));
      idle(1);
      host_cnt = TBL[i][192:129];
      wr_cnt(TBL[i][128:65]);
      idle(2);
      wr_ctl(ctlv(1'b0, v));
      wr_match(TBL[i][64:1]);
      count_sets(4, v, hits, any);
      chk($sformatf("R5 table %0d fire count", i), hits, TBL[i][0] ? 64'd1 : 64'd0);
      chk($sformatf("R5 table %0d total sets", i), any, TBL[i][0] ? 64'd1 : 64'd0);
    end

    // R8: counter write past match
    host_cnt = 64'd0;
    wr_cnt(64'd100);
    idle(2);
    wr_match(64'd200);
    chk("R7 clr_vec current vector", {56'd0, clr_vec}, 64'h64);
    wr_cnt(64'd150);
    chk("R8 no clr below match", {63'd0, clr_stb}, 64'd0);
    wr_cnt(64'd300);
    chk("R8 clr_stb past match", {63'd0, clr_stb}, 64'd1);
    chk("R8 clr_vec past match", {56'd0, clr_vec}, 64'h64);
    count_sets(4, 8'h64, hits, any);
    chk("R8 disarmed after pass", any, 64'd0);

    // R9: masked control write clears old vector
    wr_ctl(ctlv(1'b1, 8'h70));
    chk("R9 clr_stb", {63'd0, clr_stb}, 64'd1);
    chk("R9 clr_vec old", {56'd0, clr_vec}, 64'h64);

    // R10: migration
    pend_at_vec = 1'b1;
    wr_ctl(ctlv(1'b0, 8'h70));
    chk("R10 same vector no clr", {63'd0, clr_stb}, 64'd0);
    chk("R10 same vector no set", {63'd0, set_stb}, 64'd0);
    wr_ctl(ctlv(1'b0, 8'h12));
    chk("R10 migrate clr_stb", {63'd0, clr_stb}, 64'd1);
    chk("R10 migrate clr_vec", {56'd0, clr_vec}, 64'h70);
    chk("R10 migrate set_stb", {63'd0, set_stb}, 64'd1);
    chk("R10 migrate set_vec", {56'd0, set_vec}, 64'h12);
    pend_at_vec = 1'b0;
    wr_ctl(ctlv(1'b0, 8'h13));
    chk("R10 not pending no clr", {63'd0, clr_stb}, 64'd0);
    chk("R10 not pending no set", {63'd0, set_stb}, 64'd0);

    // R11: write priority
    match_wr = 1'b1; match_wdata = 64'd9999;
    ctl_wr = 1'b1; ctl_wdata = ctlv(1'b1, 8'h44);
    @(negedge clk);
    match_wr = 1'b0; ctl_wr = 1'b0;
    chk("R11 match wins clr_vec", {56'd0, clr_vec}, 64'h13);
    chk("R11 control dropped", {56'd0, probe_vec}, 64'h13);
    cnt_wr = 1'b1; cnt_wdata = 64'd5000;
    match_wr = 1'b1; match_wdata = 64'd1;
    @(negedge clk);
    cnt_wr = 1'b0; match_wr = 1'b0;
    chk("R11 counter wins no clr", {63'd0, clr_stb}, 64'd0);
    count_sets(4, 8'h13, hits, any);
    chk("R11 match dropped no fire", any, 64'd0);

    // R5: ticking host fires once
    host_cnt = 64'd0;
    wr_cnt(64'd0);
    idle(1);
    wr_match(64'd6);
    hits = 0; any = 0;
    for (int k = 0; k < 20; k++) begin
      host_cnt = host_cnt + 64'd1;
      @(negedge clk);
      if (set_stb) begin
        any++;
        if (set_vec == 8'h13) hits++;
      end
    end
    chk("R5 ticking fires once", any, 64'd1);
    chk("R5 ticking vector", hits, 64'd1);
    rd(rv, vl);
    chk("R1 read after ticking", rv, host_cnt);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule